// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Arbiter

This block sits between a set of maskable interrupt sources, one non-maskable source and a processor core. Each maskable source carries an event line, an enable bit and a 3-bit priority level set by software. The arbiter looks at every source that is both enabled and signalling. It picks the one with the highest level, breaking ties by source index. It then tests that level against the processor's current 3-bit mask level.

The processor announces instruction boundaries on a single input. When a boundary coincides with an acceptable request, the arbiter issues a one-cycle grant carrying the vector number of the winner. In the same step it raises the held mask level to the granted level, or to 7 for the non-maskable source, and pulses a strobe that clears the trace bit in the processor's extended status register. The mask level lives in a register inside the block, and the processor can also load it directly through a write port.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A maskable source is a candidate only while its event input and its enable input are both 1. A source with either input at 0 is never granted.
- R2: Among candidates, the one with the highest level wins. Source i is taken from bits [3i+2:3i] of srcLevel and reports vector 16+i. A candidate that loses stays pending and is granted later.
- R3: When several candidates share the highest level, the one with the lowest index wins.
- R4: A maskable winner is granted only if its level is strictly greater than maskLevel. A winner whose level is equal to or below maskLevel is held pending, and it is granted once the mask is lowered below its level.
- R5: A rising edge on nmiIn is latched until it is granted. It ignores the mask and beats any maskable candidate. It reports vector 7 and sets maskLevel to 7. A level held high on nmiIn does not produce a second grant.
- R6: grantValid is 1 only in the cycle after a cycle in which instrDone was 1 and a request was acceptable. It lasts one cycle per grant.
- R7: In the cycle grantValid is 1, maskLevel already shows the granted level and traceClr is 1. traceClr is 0 whenever grantValid is 0.
- R8: With maskWrEn at 1, maskLevel takes maskWrData on the next cycle, unless a grant is issued in that same cycle; in that case the grant's level is loaded and the written value is dropped.
- R9: After reset, maskLevel is 7 and grantValid and traceClr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvent | input | NUM_SRC | Level-held event per maskable source |
| srcEnable | input | NUM_SRC | Enable per maskable source |
| srcLevel | input | 3*NUM_SRC | Priority level per source, 3 bits each, source 0 lowest |
| nmiIn | input | 1 | Non-maskable request, edge-detected |
| instrDone | input | 1 | Processor is at an instruction boundary |
| maskWrEn | input | 1 | Direct load of the mask level |
| maskWrData | input | 3 | Value for the direct load |
| grantValid | output | 1 | One-cycle grant pulse |
| grantVector | output | VEC_W | Vector number of the granted request |
| maskLevel | output | 3 | Current processor mask level |
| traceClr | output | 1 | Strobe to clear the trace bit |

## Verification
A direct mask write and an acceptance update can both target the mask register in the same cycle. The bench provokes this by raising maskWrEn together with instrDone while an eligible request is pending. It expects the granted level, not the written value, in maskLevel. It then repeats the write with instrDone high but with only ineligible requests, where the written value must land.

// File: rtl/irqarb_pkg.sv
`timescale 1ns/1ps
package irqarb_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] level_t;
  localparam level_t TOP_LVL = '1;

  // strobes from control to datapath
  typedef struct packed {
    logic grant;     // accept winner this cycle
    logic takeNmi;   // winner is the non-maskable request
    logic maskLoad;  // direct mask write wins this cycle
  } strobes_t;
endpackage

// File: rtl/irqarb_ctl.sv
`timescale 1ns/1ps
module irqarb_ctl
  import irqarb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     nmiIn,
  input  logic     instrDone,
  input  logic     maskWrEn,
  input  logic     anyReq,
  input  level_t   bestLevel,
  input  level_t   maskLevel,
  output strobes_t strobes
);
  logic nmiPrev;
  logic nmiPend;
  logic nmiRise;
  logic maskOk;

  assign nmiRise = nmiIn & ~nmiPrev;

  always_comb begin
    maskOk           = anyReq && (bestLevel > maskLevel);
    strobes.takeNmi  = nmiPend;
    strobes.grant    = instrDone && (nmiPend || maskOk);
    strobes.maskLoad = maskWrEn && !strobes.grant;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiIn;
      nmiPend <= nmiRise | (nmiPend & ~strobes.grant);
    end
  end

  // R5
  nmi_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiIn) |=> nmiPend);
endmodule

// File: rtl/irqarb_dp.sv
`timescale 1ns/1ps
module irqarb_dp
  import irqarb_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16,
  parameter int NMI_VEC  = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       srcEvent,
  input  logic [NUM_SRC-1:0]       srcEnable,
  input  logic [NUM_SRC*LVL_W-1:0] srcLevel,
  input  level_t                   maskWrData,
  input  strobes_t                 strobes,
  output logic                     anyReq,
  output level_t                   bestLevel,
  output level_t                   maskLevel,
  output logic                     grantValid,
  output logic [VEC_W-1:0]         grantVector,
  output logic                     traceClr
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  level_t              lvl [NUM_SRC];
  logic [NUM_SRC-1:0]  active;
  logic [IDX_W-1:0]    bestIdx;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign lvl[g]    = srcLevel[g*LVL_W +: LVL_W];
    assign active[g] = srcEvent[g] & srcEnable[g];
  end

  // scan from the top index down; >= lets a lower index take a tie
  always_comb begin
    anyReq    = 1'b0;
    bestLevel = '0;
    bestIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i] && (!anyReq || lvl[i] >= bestLevel)) begin
        anyReq    = 1'b1;
        bestLevel = lvl[i];
        bestIdx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskLevel   <= TOP_LVL;
      grantValid  <= 1'b0;
      traceClr    <= 1'b0;
      grantVector <= '0;
    end else begin
      grantValid <= strobes.grant;
      traceClr   <= strobes.grant;
      if (strobes.grant) begin
        if (strobes.takeNmi) begin
          grantVector <= VEC_W'(NMI_VEC);
          maskLevel   <= TOP_LVL;
        end else begin
          grantVector <= VEC_W'(VEC_BASE) + VEC_W'(bestIdx);
          maskLevel   <= bestLevel;
        end
      end else if (strobes.maskLoad) begin
        maskLevel <= maskWrData;
      end
    end
  end

  // R4
  mask_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && grantVector != VEC_W'(NMI_VEC)) |-> maskLevel > $past(maskLevel));

  // R5
  nmi_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && grantVector == VEC_W'(NMI_VEC)) |-> maskLevel == TOP_LVL);
endmodule

// File: rtl/prio_irq_arbiter.sv
`timescale 1ns/1ps
module prio_irq_arbiter #(
  parameter int NUM_SRC  = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16,
  parameter int NMI_VEC  = 7
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_SRC-1:0]                   srcEvent,
  input  logic [NUM_SRC-1:0]                   srcEnable,
  input  logic [NUM_SRC*irqarb_pkg::LVL_W-1:0] srcLevel,
  input  logic                                 nmiIn,
  input  logic                                 instrDone,
  input  logic                                 maskWrEn,
  input  logic [irqarb_pkg::LVL_W-1:0]         maskWrData,
  output logic                                 grantValid,
  output logic [VEC_W-1:0]                     grantVector,
  output logic [irqarb_pkg::LVL_W-1:0]         maskLevel,
  output logic                                 traceClr
);
  import irqarb_pkg::*;

  strobes_t strobes;
  logic     anyReq;
  level_t   bestLevel;

  irqarb_ctl i_ctl (
    .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .instrDone(instrDone),
    .maskWrEn(maskWrEn), .anyReq(anyReq), .bestLevel(bestLevel),
    .maskLevel(maskLevel), .strobes(strobes)
  );

  irqarb_dp #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .NMI_VEC(NMI_VEC)) i_dp (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .srcEnable(srcEnable),
    .srcLevel(srcLevel), .maskWrData(maskWrData), .strobes(strobes),
    .anyReq(anyReq), .bestLevel(bestLevel), .maskLevel(maskLevel),
    .grantValid(grantValid), .grantVector(grantVector), .traceClr(traceClr)
  );

  // R6
  grant_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $past(instrDone));

  // R8
  mask_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(maskWrEn) && !grantValid) |-> maskLevel == $past(maskWrData));

  // R7
  trace_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> !traceClr);
endmodule

// File: tb/test_prio_irq_arbiter.sv
`timescale 1ns/1ps
module test_prio_irq_arbiter;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] srcEvent = '0;
  logic [N-1:0] srcEnable = '0;
  logic [N*3-1:0] srcLevel = '0;
  logic         nmiIn = 1'b0;
  logic         instrDone = 1'b0;
  logic         maskWrEn = 1'b0;
  logic [2:0]   maskWrData = '0;
  logic         grantValid;
  logic [7:0]   grantVector;
  logic [2:0]   maskLevel;
  logic         traceClr;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  prio_irq_arbiter i_prio_irq_arbiter (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .srcEnable(srcEnable),
    .srcLevel(srcLevel), .nmiIn(nmiIn), .instrDone(instrDone),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .grantValid(grantValid),
    .grantVector(grantVector), .maskLevel(maskLevel), .traceClr(traceClr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setLvl(input int s, input int l);
    srcLevel[s*3 +: 3] = 3'(l);
  endtask

  task automatic clearSrc();
    srcEvent = '0;
    srcEnable = '1;
    srcLevel = '0;
  endtask

  task automatic setMask(input int m);
    maskWrEn = 1'b1;
    maskWrData = 3'(m);
    tick();
    maskWrEn = 1'b0;
  endtask

  task automatic tryGrant(input string tag, input bit expG, input int expVec, input int expMask);
    instrDone = 1'b1;
    tick();
    instrDone = 1'b0;
    chk({tag, " grantValid"}, int'(grantValid), int'(expG));
    chk({tag, " traceClr"}, int'(traceClr), int'(expG));
    if (expG) chk({tag, " vector"}, int'(grantVector), expVec);
    chk({tag, " mask"}, int'(maskLevel), expMask);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R9 reset state
    chk("R9 mask", int'(maskLevel), 7);
    chk("R9 grantValid", int'(grantValid), 0);
    chk("R9 traceClr", int'(traceClr), 0);
    rstN = 1'b1;
    tick();
    chk("R9 mask after release", int'(maskLevel), 7);

    // R4 sweep: single source, every level against every mask
    for (int s = 0; s < N; s++) begin
      for (int l = 0; l < 8; l++) begin
        for (int m = 0; m < 8; m++) begin
          clearSrc();
          srcEvent[s] = 1'b1;
          setLvl(s, l);
          setMask(m);
          tryGrant("R4 sweep", l > m, 16 + s, (l > m) ? l : m);
          if (l <= m && l > 0) begin
            setMask(0);
            tryGrant("R4 pending", 1'b1, 16 + s, l);
          end
        end
      end
    end

    // R2/R3 sweep: pairs of sources at all nonzero levels
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        for (int li = 1; li < 8; li++) begin
          for (int lj = 1; lj < 8; lj++) begin
            int w;
            int wl;
            clearSrc();
            srcEvent[i] = 1'b1;
            srcEvent[j] = 1'b1;
            setLvl(i, li);
            setLvl(j, lj);
            setMask(0);
            w  = (lj > li) ? j : i;
            wl = (lj > li) ? lj : li;
            tryGrant((li == lj) ? "R3 tie" : "R2 level", 1'b1, 16 + w, wl);
          end
        end
      end
    end

    // R2 loser is not lost
    clearSrc();
    srcEvent[1] = 1'b1; setLvl(1, 2);
    srcEvent[5] = 1'b1; setLvl(5, 6);
    setMask(0);
    tryGrant("R2 first", 1'b1, 21, 6);
    srcEvent[5] = 1'b0;
    setMask(0);
    tryGrant("R2 loser kept", 1'b1, 17, 2);

    // R1 event without enable, enable without event
    for (int s = 0; s < N; s++) begin
      clearSrc();
      srcEvent[s] = 1'b1;
      srcEnable[s] = 1'b0;
      setLvl(s, 7);
      setMask(0);
      tryGrant("R1 disabled", 1'b0, 0, 0);
      srcEvent[s] = 1'b0;
      srcEnable[s] = 1'b1;
      tryGrant("R1 no event", 1'b0, 0, 0);
    end

    // R5 non-maskable: ignores a full mask
    clearSrc();
    srcEvent[2] = 1'b1; setLvl(2, 7);
    setMask(7);
    nmiIn = 1'b1;
    tick();
    tryGrant("R5 nmi over mask 7", 1'b1, 7, 7);
    tryGrant("R5 held nmi no regrant", 1'b0, 0, 7);
    setMask(6);
    tryGrant("R5 maskable after nmi", 1'b1, 18, 7);
    nmiIn = 1'b0;
    tick();
    // R5 beats top maskable, maskable stays pending
    clearSrc();
    srcEvent[0] = 1'b1; setLvl(0, 7);
    setMask(0);
    nmiIn = 1'b1;
    tick();
    tryGrant("R5 nmi beats maskable", 1'b1, 7, 7);
    setMask(0);
    tryGrant("R5 maskable pending", 1'b1, 16, 7);
    nmiIn = 1'b0;
    tick();

    // R6 no grant without boundary; latched edge waits
    clearSrc();
    srcEvent[3] = 1'b1; setLvl(3, 6);
    setMask(0);
    nmiIn = 1'b1;
    tick();
    nmiIn = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R6 no boundary", int'(grantValid), 0);
    end
    tryGrant("R6 nmi latched", 1'b1, 7, 7);
    tick();
    chk("R6 pulse ends", int'(grantValid), 0);
    chk("R7 trace ends", int'(traceClr), 0);
    setMask(0);
    tryGrant("R7 maskable", 1'b1, 19, 6);
    tick();
    chk("R6 single pulse", int'(grantValid), 0);

    // R8 write and grant in the same cycle
    clearSrc();
    srcEvent[4] = 1'b1; setLvl(4, 5);
    setMask(2);
    maskWrEn = 1'b1; maskWrData = 3'd0;
    tryGrant("R8 grant beats write", 1'b1, 20, 5);
    maskWrEn = 1'b0;
    setLvl(4, 1);
    setMask(2);
    maskWrEn = 1'b1; maskWrData = 3'd6;
    tryGrant("R8 write lands no grant", 1'b0, 0, 6);
    maskWrEn = 1'b0;
    setMask(4);
    chk("R8 plain write", int'(maskLevel), 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule